// File: doc/BRIEF.md
# Two-Wire Debug Target Protocol Engine

This block is the target half of a two-wire serial debug link. On each rising edge of the host clock it samples the shared data line and hunts for a start bit. It then gathers and checks an eight-bit request and answers with a three-bit acknowledge. When the acknowledge is OK, it either takes in a 33-bit write word from the host or drives out a 33-bit read word. The line is released for one turnaround cycle at every change of driver. The engine produces the line's output value and its output enable; the pad and its pull-up lie outside the block.

On its register side, the engine presents the decoded request as three signals: port select, read flag and a two-bit address. It also presents the write word and a one-cycle strobe. In return it takes the read word plus busy and fault levels, which choose the acknowledge. All timing below counts rising clock edges. Edge e0 samples the start bit, e1 to e7 sample the remaining request bits, and e8 is the turnaround edge.

Top module: `swd_target_engine`

## Requirements
- R1: While reset is high and in the first cycle after reset, `swd_oe`, `req_strobe` and `sticky_err` are all 0.
- R2: The request is sent LSB first. In order, its bits are: start (1), port select, read flag, address bit 0, address bit 1, parity, stop (0), park (line pulled up, read as 1). The parity bit is even parity over the four bits between start and parity. The line stays undriven through the request and through turnaround edge e8. A valid request puts its fields on `req_ap`, `req_read` and `req_addr` after e7.
- R3: The acknowledge is driven LSB first after edges e8, e9 and e10. Its codes are OK=3'b001, WAIT=3'b010 and FAULT=3'b100. Fault has priority over busy, and busy has priority over OK. Both levels are sampled at e7.
- R4: For an OK read, `req_strobe` pulses for one cycle after e7. `rd_data` is captured at e10. Bits 0 to 31 are driven after e11 to e42, and an even parity bit is driven after e43.
- R5: After a read's data phase, the line is released after e44.
- R6: For an OK write, the line is released after e11. Data bits 0 to 31 are sampled at e12 to e43 and the parity bit at e44. If parity is even, `wr_data` takes the word and `req_strobe` pulses for one cycle after e44.
- R7: A write whose data parity is odd raises no strobe and leaves `wr_data` unchanged. It sets `sticky_err`, which then stays at 1 until reset.
- R8: A request with a bad parity, a stop of 1 or a park of 0 gets no reply. The line stays undriven, there is no strobe, and the engine hunts for the next start bit.
- R9: A WAIT or FAULT acknowledge has no data phase and raises no strobe. The line is released after e11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host serial clock |
| rst | input | 1 | Synchronous active-high reset |
| swd_in | input | 1 | Sampled data line |
| swd_out | output | 1 | Value driven on the data line |
| swd_oe | output | 1 | Drive enable for the data line |
| req_ap | output | 1 | Request targets the access-port side |
| req_read | output | 1 | Request is a read |
| req_addr | output | 2 | Register address of the request |
| wr_data | output | DATA_W | Captured write word |
| req_strobe | output | 1 | One-cycle register access pulse |
| rd_data | input | DATA_W | Read word from the register side |
| ack_wait | input | 1 | Register side busy |
| ack_fault | input | 1 | Register side in fault |
| sticky_err | output | 1 | Write data parity error seen |

## Verification
The cases hardest to reach from the ports are the malformed requests. Each must be left unanswered, and the engine must still frame the next request correctly. The bench builds requests bit by bit, corrupting one field at a time: parity, stop and park. It watches that the line stays undriven, then runs a good read straight after to prove the hunt restarted. A write with a flipped data parity bit is sent after a good write, so the test shows both that the strobe is withheld and that the earlier write word survives.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int ACK_W = 3;
  localparam int REQ_BODY_W = 7;  // request bits after the start bit

  localparam logic [ACK_W-1:0] ACK_OK    = 3'b001;
  localparam logic [ACK_W-1:0] ACK_WAIT  = 3'b010;
  localparam logic [ACK_W-1:0] ACK_FAULT = 3'b100;

  typedef enum logic [2:0] {
    S_HUNT,
    S_REQ,
    S_TRN,
    S_ACK,
    S_WDATA,
    S_RDATA
  } link_state_t;

  typedef struct packed {
    logic       ap;
    logic       rd;
    logic [1:0] addr;
  } req_fields_t;
endpackage

// File: rtl/swd_req_check.sv
module swd_req_check
  import swd_pkg::*;
(
  input  logic [REQ_BODY_W-1:0] body,   // [0]=port [1]=read [3:2]=addr [4]=par [5]=stop [6]=park
  output logic                  valid,
  output req_fields_t           fields
);
  logic par_ok;

  always_comb begin
    par_ok        = ((body[0] ^ body[1] ^ body[2] ^ body[3]) == body[4]);
    valid         = par_ok && !body[5] && body[6];
    fields.ap     = body[0];
    fields.rd     = body[1];
    fields.addr   = body[3:2];
  end
endmodule

// File: rtl/swd_ack_select.sv
module swd_ack_select
  import swd_pkg::*;
(
  input  logic             busy,
  input  logic             fault,
  output logic [ACK_W-1:0] code
);
  always_comb begin
    if (fault)     code = ACK_FAULT;
    else if (busy) code = ACK_WAIT;
    else           code = ACK_OK;
  end
endmodule

// File: rtl/swd_target_engine.sv
module swd_target_engine
  import swd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              swd_in,
  output logic              swd_out,
  output logic              swd_oe,
  output logic              req_ap,
  output logic              req_read,
  output logic [1:0]        req_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              req_strobe,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              ack_wait,
  input  logic              ack_fault,
  output logic              sticky_err
);
  localparam int PH_W  = DATA_W + 1;
  localparam int CNT_W = $clog2(PH_W + 1);
  localparam logic [CNT_W-1:0] REQ_LAST  = CNT_W'(REQ_BODY_W - 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] RD_END    = CNT_W'(PH_W);
  localparam logic [CNT_W-1:0] ACK_LOAD  = CNT_W'(2);
  localparam logic [CNT_W-1:0] ACK_END   = CNT_W'(ACK_W);

  link_state_t            state;
  logic [CNT_W-1:0]       cnt;
  logic [REQ_BODY_W-1:0]  req_sh;
  logic [PH_W-1:0]        dsh;
  logic [ACK_W-1:0]       ack_q;
  logic [REQ_BODY_W-1:0]  body_now;
  logic [PH_W-1:0]        wfull;
  logic                   body_ok;
  req_fields_t            body_f;
  logic [ACK_W-1:0]       ack_now;
  logic                   ack_is_ok;

  assign body_now  = {swd_in, req_sh[REQ_BODY_W-1:1]};
  assign wfull     = {swd_in, dsh[PH_W-1:1]};
  assign ack_is_ok = (ack_q == ACK_OK);

  swd_req_check u_check (
    .body   (body_now),
    .valid  (body_ok),
    .fields (body_f)
  );

  swd_ack_select u_ack (
    .busy  (ack_wait),
    .fault (ack_fault),
    .code  (ack_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_HUNT;
      cnt        <= '0;
      req_sh     <= '0;
      dsh        <= '0;
      ack_q      <= ACK_OK;
      swd_out    <= 1'b0;
      swd_oe     <= 1'b0;
      req_ap     <= 1'b0;
      req_read   <= 1'b0;
      req_addr   <= '0;
      wr_data    <= '0;
      req_strobe <= 1'b0;
      sticky_err <= 1'b0;
    end else begin
      req_strobe <= 1'b0;
      unique case (state)
        S_HUNT: begin
          if (swd_in) begin
            state <= S_REQ;
            cnt   <= '0;
          end
        end
        S_REQ: begin
          req_sh <= body_now;
          cnt    <= cnt + 1'b1;
          if (cnt == REQ_LAST) begin
            if (body_ok) begin
              req_ap   <= body_f.ap;
              req_read <= body_f.rd;
              req_addr <= body_f.addr;
              ack_q    <= ack_now;
              state    <= S_TRN;
              if (body_f.rd && ack_now == ACK_OK) req_strobe <= 1'b1;
            end else begin
              state <= S_HUNT;
            end
          end
        end
        S_TRN: begin
          swd_oe  <= 1'b1;
          swd_out <= ack_q[0];
          cnt     <= CNT_W'(1);
          state   <= S_ACK;
        end
        S_ACK: begin
          if (cnt != ACK_END) begin
            swd_out <= ack_q[cnt[1:0]];
            cnt     <= cnt + 1'b1;
            if (cnt == ACK_LOAD && ack_is_ok && req_read)
              dsh <= {^rd_data, rd_data};
          end else if (ack_is_ok && req_read) begin
            swd_out <= dsh[0];
            cnt     <= CNT_W'(1);
            state   <= S_RDATA;
          end else begin
            swd_oe  <= 1'b0;
            swd_out <= 1'b0;
            cnt     <= '0;
            state   <= (ack_is_ok) ? S_WDATA : S_HUNT;
          end
        end
        S_RDATA: begin
          if (cnt == RD_END) begin
            swd_oe  <= 1'b0;
            swd_out <= 1'b0;
            state   <= S_HUNT;
          end else begin
            swd_out <= dsh[cnt];
            cnt     <= cnt + 1'b1;
          end
        end
        S_WDATA: begin
          dsh <= wfull;
          cnt <= cnt + 1'b1;
          if (cnt == WR_LAST) begin
            if (^wfull == 1'b0) begin
              wr_data    <= wfull[DATA_W-1:0];
              req_strobe <= 1'b1;
            end else begin
              sticky_err <= 1'b1;
            end
            state <= S_HUNT;
          end
        end
        default: state <= S_HUNT;
      endcase
    end
  end

  // R2: the target never drives while hunting, collecting a request, or turning around
  a_r2_quiet_in_request: assert property (@(posedge clk) disable iff (rst)
    (state == S_HUNT || state == S_REQ || state == S_TRN) |-> !swd_oe);

  // R3: the driver switches on only right after the turnaround cycle
  a_r3_drive_after_trn: assert property (@(posedge clk) disable iff (rst)
    $rose(swd_oe) |-> $past(state) == S_TRN);

  // R3: the answered code is one of the three one-hot values
  a_r3_ack_onehot: assert property (@(posedge clk) disable iff (rst)
    (state == S_ACK) |-> $countones(ack_q) == 1);

  // R4: the access strobe is a single-cycle pulse
  a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    req_strobe |=> !req_strobe);

  // R7: the data parity error flag stays set until reset
  a_r7_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    sticky_err |=> sticky_err);

  // R9: no strobe is raised after a non-OK answer
  a_r9_no_strobe_on_reject: assert property (@(posedge clk) disable iff (rst)
    (state == S_ACK && !ack_is_ok) |-> !req_strobe);
endmodule

// File: tb/swd_target_engine_tb.sv
module swd_target_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          swd_in = 1'b0;
  logic          swd_out, swd_oe;
  logic          req_ap, req_read, req_strobe, sticky_err;
  logic [1:0]    req_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data = '0;
  logic          ack_wait = 1'b0, ack_fault = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swd_target_engine #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .swd_in(swd_in), .swd_out(swd_out), .swd_oe(swd_oe),
    .req_ap(req_ap), .req_read(req_read), .req_addr(req_addr), .wr_data(wr_data),
    .req_strobe(req_strobe), .rd_data(rd_data), .ack_wait(ack_wait),
    .ack_fault(ack_fault), .sticky_err(sticky_err)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic b);
    @(negedge clk);
    swd_in = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  // sends start..park; leaves the bench just before the edge that samples park
  task automatic send_req(input logic ap, input logic rd, input logic [1:0] a,
                          input logic par_flip, input logic stop_v, input logic park_v);
    logic p;
    p = ap ^ rd ^ a[0] ^ a[1] ^ par_flip;
    step(1'b1); step(ap); step(rd); step(a[0]); step(a[1]);
    step(p); step(stop_v); step(park_v);
  endtask

  function automatic logic [2:0] exp_ack(input logic w, input logic f);
    if (f) return 3'b100;
    if (w) return 3'b010;
    return 3'b001;
  endfunction

  task automatic do_read(input logic ap, input logic [1:0] a, input logic [DW-1:0] d,
                         input logic w, input logic f);
    logic [2:0] ea;
    logic [DW:0] word;
    bit mism;
    ea = exp_ack(w, f);
    rd_data = d; ack_wait = w; ack_fault = f;
    word = {^d, d};
    idle(2);
    send_req(ap, 1'b1, a, 1'b0, 1'b0, 1'b1);
    step(1'b1);  // after e7
    check(!swd_oe, "R2 read undriven at turnaround", swd_oe, 0);
    check(req_strobe == (ea == 3'b001), "R4 read strobe after request", req_strobe, ea == 3'b001);
    check({req_ap, req_read, req_addr} == {ap, 1'b1, a}, "R2 read fields", {req_ap, req_read, req_addr}, {ap, 1'b1, a});
    for (int i = 0; i < 3; i++) begin
      step(1'b1);
      check(swd_oe && swd_out == ea[i], "R3 ack bit", {swd_oe, swd_out}, {1'b1, ea[i]});
    end
    if (ea == 3'b001) begin
      mism = 1'b0;
      for (int i = 0; i <= DW; i++) begin
        step(1'b1);
        if (!swd_oe || swd_out != word[i]) begin
          mism = 1'b1;
          $display("FAIL R4 read bit %0d actual=%0b expected=%0b", i, swd_out, word[i]);
        end
      end
      check(!mism, "R4 read data and parity", mism, 0);
      step(1'b0);
      check(!swd_oe, "R5 release after read", swd_oe, 0);
    end else begin
      step(1'b0);
      check(!swd_oe && !req_strobe, "R9 release after reject", {swd_oe, req_strobe}, 0);
      idle(1);
      check(!swd_oe, "R9 no data phase", swd_oe, 0);
    end
    ack_wait = 1'b0; ack_fault = 1'b0;
    idle(2);
  endtask

  task automatic do_write(input logic ap, input logic [1:0] a, input logic [DW-1:0] d,
                          input logic par_flip, input logic [DW-1:0] exp_keep);
    logic [DW:0] word;
    word = {(^d) ^ par_flip, d};
    idle(2);
    send_req(ap, 1'b0, a, 1'b0, 1'b0, 1'b1);
    step(1'b1);
    check(!req_strobe && {req_ap, req_read, req_addr} == {ap, 1'b0, a}, "R2 write fields",
          {req_strobe, req_ap, req_read, req_addr}, {1'b0, ap, 1'b0, a});
    for (int i = 0; i < 3; i++) begin
      step(1'b1);
      check(swd_oe && swd_out == (i == 0), "R3 write ack OK", {swd_oe, swd_out}, {1'b1, i == 0});
    end
    @(negedge clk);
    check(!swd_oe, "R6 release before write data", swd_oe, 0);
    swd_in = word[0];
    for (int i = 1; i <= DW; i++) step(word[i]);
    step(1'b0);
    if (!par_flip) begin
      check(req_strobe && wr_data == d, "R6 write strobe and data", {req_strobe, wr_data}, {1'b1, d});
    end else begin
      check(!req_strobe && wr_data == exp_keep, "R7 bad parity no strobe", {req_strobe, wr_data}, {1'b0, exp_keep});
      check(sticky_err, "R7 sticky set", sticky_err, 1);
    end
    idle(1);
    check(!req_strobe, "R6 strobe single pulse", req_strobe, 0);
    idle(2);
  endtask

  task automatic do_bad_req(input logic par_flip, input logic stop_v, input logic park_v, input string tag);
    bit seen;
    idle(2);
    send_req(1'b0, 1'b1, 2'b01, par_flip, stop_v, park_v);
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1'b0);
      if (swd_oe || req_strobe) seen = 1'b1;
    end
    check(!seen, tag, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!swd_oe && !req_strobe && !sticky_err, "R1 state in reset", {swd_oe, req_strobe, sticky_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!swd_oe && !req_strobe && !sticky_err, "R1 state after reset", {swd_oe, req_strobe, sticky_err}, 0);

    do_read(1'b0, 2'b00, 32'hA5C3_0F81, 1'b0, 1'b0);
    do_read(1'b1, 2'b11, 32'h0000_0001, 1'b0, 1'b0);
    do_read(1'b1, 2'b10, 32'hFFFF_FFFF, 1'b1, 1'b0);   // R3 busy -> WAIT, R9
    do_read(1'b0, 2'b01, 32'h1234_5678, 1'b1, 1'b1);   // R3 fault beats busy
    do_write(1'b1, 2'b01, 32'hDEAD_BEEF, 1'b0, '0);
    do_write(1'b0, 2'b10, 32'h8000_0003, 1'b0, '0);
    do_write(1'b0, 2'b11, 32'h0F0F_0001, 1'b1, 32'h8000_0003);
    do_bad_req(1'b1, 1'b0, 1'b1, "R8 bad parity ignored");
    do_read(1'b0, 2'b01, 32'h5555_AAAA, 1'b0, 1'b0);   // R8 hunt restarted
    do_bad_req(1'b0, 1'b1, 1'b1, "R8 bad stop ignored");
    do_bad_req(1'b0, 1'b0, 1'b0, "R8 bad park ignored");
    do_read(1'b1, 2'b00, 32'h0000_8000, 1'b0, 1'b0);
    check(sticky_err, "R7 sticky still set", sticky_err, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule